// File: doc/BRIEF.md
# Finite-Difference Quadratic Sequencer

This block steps through the values of a second-order polynomial using adders alone. Three registers hold a running value, a running first difference and a fixed second difference. Each accepted step adds the second difference into the first difference, then adds that updated first difference into the value. Both additions settle in the same clock, so every step costs one cycle and needs no multiplier.

The surrounding logic supplies the seeds. For a target polynomial a·n² + b·n + c, the seeds are value = c, first difference = b − a and second difference = 2a. The block then reports f(n) on its value output and n on its index output. A one-cycle valid pulse marks each new result. All arithmetic wraps modulo 2^W, and a sticky flag records any carry out of either adder.

Top module: `fdpg_top`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, valid_o, value_o, index_o and overflow_o are all zero.
- R2: A load_i sampled high at a clock edge makes value_o equal seed_value_i from the next cycle on. It also sets index_o to 0, drives valid_o low and clears overflow_o.
- R3: When load_i and step_i are high in the same cycle, the load takes effect and the step is discarded: index_o becomes 0 and valid_o stays low.
- R4: An accepted step (step_i high, load_i low) first forms d1' = d1 + d2 and then sets value_o to value_o + d1', all within one clock. With seeds 41, 0, 2 the first four results are 43, 47, 53 and 61.
- R5: Each accepted step raises index_o by exactly one, modulo 2^W.
- R6: valid_o is high for exactly the one cycle that follows each accepted step and is low at all other times.
- R7: In a cycle with neither load_i nor step_i, value_o, index_o and the internal differences keep their values. A later step therefore continues the sequence without a gap.
- R8: All sums wrap modulo 2^W. overflow_o goes high after any step in which either the difference sum or the value sum carries out of W bits. It then stays high until the next load.
- R9: The second difference stays at its loaded value across steps. For seeds (c, b − a, 2a), the k-th result after a load equals a·k² + b·k + c modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| load_i | input | 1 | Load the three seeds and restart the index |
| seed_value_i | input | W | Starting value f(0) |
| seed_diff1_i | input | W | Starting first difference |
| seed_diff2_i | input | W | Constant second difference |
| step_i | input | 1 | Advance to the next polynomial value |
| valid_o | output | 1 | One-cycle pulse after each accepted step |
| value_o | output | W | Current value f(n) |
| index_o | output | W | Current index n |
| overflow_o | output | 1 | Sticky carry-out indicator, cleared by load |

## Verification
The assertions assume that rst_n changes are already synchronised to clk and that load_i and step_i are valid at every sampled edge. They do not assume the two strobes are exclusive, so the simultaneous case is legal and is exercised on purpose. The stimulus changes inputs only on the falling edge, keeps every strobe high for exactly one cycle, and runs with the default 32-bit width. The expected sequences come from closed-form quadratics: several coefficient sets, sixty-four steps on the reference polynomial, idle gaps between steps, and seeds chosen near the top of the range to force each adder to carry.

// File: rtl/fdpg_pkg.sv
package fdpg_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } fdpg_act_e;

  // load wins over step
  function automatic fdpg_act_e fdpg_decode(input logic load, input logic step);
    if (load)      return ACT_LOAD;
    else if (step) return ACT_STEP;
    else           return ACT_IDLE;
  endfunction
endpackage

// File: rtl/fdpg_acc_stage.sv
module fdpg_acc_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] seed_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int SW = W + 1;

  logic [SW-1:0] sum_full;
  logic [W-1:0]  acc_q, acc_d;
  logic          acc_en;

  always_comb begin
    sum_full = {1'b0, acc_q} + {1'b0, addend_i};
    acc_en   = load_i | step_i;
    acc_d    = load_i ? seed_i : sum_full[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o   = acc_q;
  assign sum_o   = sum_full[W-1:0];
  assign carry_o = sum_full[W];

  // R7: idle cycles leave the accumulator untouched
  p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(acc_o));

  // R2: a load places the seed in the accumulator
  p_stage_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_o == $past(seed_i)));
endmodule

// File: rtl/fdpg_index_ctr.sv
module fdpg_index_ctr #(
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          inc_i,
  output logic [IW-1:0] count_o
);
  logic [IW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i | inc_i;
    cnt_d  = clear_i ? '0 : cnt_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R5: an increment without clear advances by one, modulo 2^IW
  p_index_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clear_i) |=> (count_o == $past(count_o) + IW'(1)));

  // R2: clear returns the index to zero
  p_index_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0));
endmodule

// File: rtl/fdpg_top.sv
module fdpg_top #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_value_i,
  input  logic [W-1:0] seed_diff1_i,
  input  logic [W-1:0] seed_diff2_i,
  input  logic         step_i,
  output logic         valid_o,
  output logic [W-1:0] value_o,
  output logic [W-1:0] index_o,
  output logic         overflow_o
);
  import fdpg_pkg::*;

  fdpg_act_e    act;
  logic         do_load, do_step;
  logic [W-1:0] d2_q, d2_d;
  logic         d2_en;
  logic [W-1:0] d1_acc, d1_next;
  logic         d1_carry;
  logic [W-1:0] f_acc, f_next;
  logic         f_carry;
  logic         valid_q, valid_d;
  logic         ovf_q, ovf_d;

  always_comb begin
    act     = fdpg_decode(load_i, step_i);
    do_load = (act == ACT_LOAD);
    do_step = (act == ACT_STEP);
  end

  // constant second difference
  always_comb begin
    d2_en = do_load;
    d2_d  = seed_diff2_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     d2_q <= '0;
    else if (d2_en) d2_q <= d2_d;
  end

  // first difference: d1 + d2
  fdpg_acc_stage #(.W(W)) u_diff1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (do_load),
    .step_i   (do_step),
    .seed_i   (seed_diff1_i),
    .addend_i (d2_q),
    .acc_o    (d1_acc),
    .sum_o    (d1_next),
    .carry_o  (d1_carry)
  );

  // value: f + (updated d1)
  fdpg_acc_stage #(.W(W)) u_value (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (do_load),
    .step_i   (do_step),
    .seed_i   (seed_value_i),
    .addend_i (d1_next),
    .acc_o    (f_acc),
    .sum_o    (f_next),
    .carry_o  (f_carry)
  );

  fdpg_index_ctr #(.IW(W)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (do_load),
    .inc_i   (do_step),
    .count_o (index_o)
  );

  always_comb begin
    valid_d = do_step;
    ovf_d   = ovf_q;
    if (do_load)      ovf_d = 1'b0;
    else if (do_step) ovf_d = ovf_q | d1_carry | f_carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  assign value_o    = f_acc;
  assign valid_o    = valid_q;
  assign overflow_o = ovf_q;

  // R6: a valid pulse only follows an accepted step
  p_valid_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(step_i && !load_i));

  // R3: a load alongside a step suppresses valid and restarts the index
  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && step_i) |=> (!valid_o && index_o == '0));

  // R8: overflow stays set until a load
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !load_i) |=> overflow_o);

  // R2: a load clears overflow and shows the seed value
  p_load_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!overflow_o && value_o == $past(seed_value_i)));

  // R9: the second difference never changes between loads
  p_d2_const_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(d2_q));
endmodule

// File: tb/tb_fdpg_top.sv
module tb_fdpg_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i, step_i;
  logic [W-1:0] seed_value_i, seed_diff1_i, seed_diff2_i;
  logic         valid_o, overflow_o;
  logic [W-1:0] value_o, index_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fdpg_top #(.W(W)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .seed_value_i (seed_value_i),
    .seed_diff1_i (seed_diff1_i),
    .seed_diff2_i (seed_diff2_i),
    .step_i       (step_i),
    .valid_o      (valid_o),
    .value_o      (value_o),
    .index_o      (index_o),
    .overflow_o   (overflow_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] quad(input longint a, input longint b, input longint c, input longint k);
    return W'(a * k * k + b * k + c);
  endfunction

  // seeds for a*n^2 + b*n + c
  task automatic load_quad(input longint a, input longint b, input longint c);
    @(negedge clk);
    load_i = 1'b1;
    seed_value_i = W'(c);
    seed_diff1_i = W'(b - a);
    seed_diff2_i = W'(2 * a);
    @(negedge clk);
    load_i = 1'b0;
    chk("R2 value after load", value_o, W'(c));
    chk("R2 index after load", index_o, '0);
    chk("R2 valid after load", {31'd0, valid_o}, '0);
    chk("R2 overflow after load", {31'd0, overflow_o}, '0);
  endtask

  task automatic do_step();
    @(negedge clk);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic run_quad(input longint a, input longint b, input longint c, input int steps, input bit gaps);
    load_quad(a, b, c);
    for (int k = 1; k <= steps; k++) begin
      do_step();
      chk("R4 R9 value", value_o, quad(a, b, c, k));
      chk("R5 index", index_o, W'(k));
      chk("R6 valid pulse", {31'd0, valid_o}, 32'd1);
      if (gaps && (k % 3 == 0)) begin
        @(negedge clk);
        chk("R6 valid drops", {31'd0, valid_o}, '0);
        @(negedge clk);
        chk("R7 idle value", value_o, quad(a, b, c, k));
        chk("R7 idle index", index_o, W'(k));
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    load_i = 1'b0;
    step_i = 1'b0;
    seed_value_i = '0;
    seed_diff1_i = '0;
    seed_diff2_i = '0;
    #35;
    chk("R1 value in reset", value_o, '0);
    chk("R1 valid in reset", {31'd0, valid_o}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 value", value_o, '0);
    chk("R1 index", index_o, '0);
    chk("R1 overflow", {31'd0, overflow_o}, '0);

    // reference sequence: first four are 43 47 53 61
    load_quad(1, 1, 41);
    do_step(); chk("R4 f1", value_o, 32'd43);
    do_step(); chk("R4 f2", value_o, 32'd47);
    do_step(); chk("R4 f3", value_o, 32'd53);
    do_step(); chk("R4 f4", value_o, 32'd61);

    run_quad(1, 1, 41, 64, 1'b0);
    run_quad(3, 7, 100, 20, 1'b1);
    run_quad(0, 5, 9, 10, 1'b0);
    run_quad(2, 0, 0, 12, 1'b1);
    run_quad(-4, 1000, 5, 16, 1'b0);

    // R3: load and step together
    load_quad(1, 1, 41);
    do_step(); do_step();
    @(negedge clk);
    load_i = 1'b1; step_i = 1'b1;
    seed_value_i = 32'd77; seed_diff1_i = 32'd0; seed_diff2_i = 32'd2;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
    chk("R3 value", value_o, 32'd77);
    chk("R3 index", index_o, '0);
    chk("R3 valid", {31'd0, valid_o}, '0);
    do_step();
    chk("R3 next value", value_o, 32'd79);

    // R8: value sum wraps and sets overflow
    @(negedge clk);
    load_i = 1'b1;
    seed_value_i = 32'hFFFF_FFF0; seed_diff1_i = 32'h10; seed_diff2_i = 32'd0;
    @(negedge clk);
    load_i = 1'b0;
    do_step();
    chk("R8 wrap value", value_o, 32'd0);
    chk("R8 overflow set", {31'd0, overflow_o}, 32'd1);
    @(negedge clk); @(negedge clk);
    chk("R8 overflow sticky", {31'd0, overflow_o}, 32'd1);
    do_step();
    chk("R8 after wrap", value_o, 32'h10);
    chk("R8 still sticky", {31'd0, overflow_o}, 32'd1);
    load_quad(0, 0, 5);

    // R8: difference sum carries while value sum does not
    @(negedge clk);
    load_i = 1'b1;
    seed_value_i = 32'd3; seed_diff1_i = 32'hFFFF_FFFF; seed_diff2_i = 32'd1;
    @(negedge clk);
    load_i = 1'b0;
    chk("R8 clean before", {31'd0, overflow_o}, '0);
    do_step();
    chk("R8 diff carry value", value_o, 32'd3);
    chk("R8 diff carry flag", {31'd0, overflow_o}, 32'd1);

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule